// File: doc/BRIEF.md
# Hot-Plug I/O Expander Polling Sequencer

This block drives up to six remote 16-bit I/O expanders that carry hot-plug control and status pins. Each slot has its own configuration: a hot-plug-capable bit, a flag that marks it as a memory-module slot or an expansion-card slot, a flag that turns off expander support for card slots, a 7-bit device address, a direction pattern and a requested output pattern. The block turns these into single-byte register commands for an external SMBus master. The commands use a request/acknowledge handshake.

A slot becomes usable when its qualification turns true. The block then programs that slot's expander: both configuration (direction) bytes first, then both output bytes. After that it polls without end. For each usable slot, in ascending order, it reads both input bytes and writes both output bytes. Input bytes that are read back are kept in per-slot registers, and each update is marked by a one-clock strobe. The polarity registers are never addressed. Until some slot qualifies, the block issues no commands at all.

Top module: `hp_expander_seq`

## Requirements
- R1: After reset `cmd_req` is 0, `slot_in` is all zero and `slot_in_upd` is 0. No command is issued while no slot qualifies.
- R2: A slot with `slot_mem`=0 qualifies only when `slot_cap`=1 and `slot_novpp`=0. A slot with `slot_mem`=1 qualifies when `slot_cap`=1, whatever `slot_novpp` is. A slot that does not qualify is never addressed.
- R3: When a slot's qualification rises, its expander is programmed with four writes in this order: offset 6 with direction low byte (`slot_dir` bits 7:0), offset 7 with direction high byte (bits 15:8), offset 2 with drive low byte (`slot_drive` bits 7:0), offset 3 with drive high byte (bits 15:8).
- R4: A pending programming sequence takes priority over polling at the next command boundary. The command in flight is completed first, and the sequence starts with the very next command.
- R5: Offsets 4 and 5 (polarity) are never issued.
- R6: One poll of a slot is four commands: read offset 0, read offset 1, write offset 2 with drive low byte, write offset 3 with drive high byte. `cmd_wr` is 1 for offsets 2, 3, 6 and 7, and 0 for offsets 0 and 1.
- R7: After a slot's poll completes, the next poll goes to the next qualifying slot in ascending index order, wrapping from the highest to the lowest. Slots that do not qualify are skipped.
- R8: A completed read of offset 0 (or 1) stores `cmd_rdata` into bits 7:0 (or 15:8) of that slot's 16-bit field in `slot_in`. It also raises that slot's bit of `slot_in_upd` for exactly one clock.
- R9: When no slot qualifies any more, the block finishes the command in flight and then issues nothing further.
- R10: While `cmd_req`=1 and `cmd_ack`=0, all command fields stay stable. `cmd_req` falls on the clock after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_cap | input | NUM_SLOTS | Per-slot hot-plug-capable bit |
| slot_mem | input | NUM_SLOTS | 1: memory-module slot, 0: expansion-card slot |
| slot_novpp | input | NUM_SLOTS | Expander disable for card slots |
| slot_dev | input | NUM_SLOTS*7 | Per-slot 7-bit device address |
| slot_dir | input | NUM_SLOTS*16 | Per-slot direction pattern |
| slot_drive | input | NUM_SLOTS*16 | Per-slot requested output pattern |
| slot_in | output | NUM_SLOTS*16 | Per-slot sampled input pattern |
| slot_in_upd | output | NUM_SLOTS | Per-slot one-clock update strobe |
| cmd_req | output | 1 | Command request |
| cmd_dev | output | 7 | Device address of the command |
| cmd_off | output | 3 | Register offset |
| cmd_wr | output | 1 | 1 write, 0 read |
| cmd_wdata | output | 8 | Write byte |
| cmd_ack | input | 1 | Command completed (one clock) |
| cmd_rdata | input | 8 | Read byte, valid with `cmd_ack` |

## Verification
The bench turns on a new slot while a poll of another slot is half done. A block that aborted the transfer in flight, or that waited for the end of the poll group, would place the programming writes at the wrong index in the command log. It also turns on a card slot with the expander disable set and then clears that flag. A design that ignored the flag would address the slot too early, and one that watched only the capable bit would never program the slot. With three slots enabled at gapped indices, the slot order is checked across the wrap and across the skipped slots. At the end every slot is disabled: the bus must fall silent, and each slot's sampled bytes and strobe count must match the reads that were acknowledged, which catches strobes that stretch or a wrong byte lane.

// File: rtl/hp_seq_pkg.sv
`timescale 1ns/1ps
package hp_seq_pkg;
  localparam int SLOT_MAX = 8;
  localparam int SIDX_W   = 3;

  typedef logic [SLOT_MAX-1:0] slot_vec_t;
  typedef logic [SIDX_W-1:0]   sidx_t;

  // lowest index with its bit set (0 when none)
  function automatic sidx_t lowest_set(slot_vec_t v);
    sidx_t r;
    r = '0;
    for (int i = SLOT_MAX - 1; i >= 0; i--) begin
      if (v[i]) r = sidx_t'(i);
    end
    return r;
  endfunction

  // next set index strictly after cur, wrapping within n slots; cur itself last
  function automatic sidx_t next_set_after(slot_vec_t v, sidx_t cur, int n);
    sidx_t r;
    logic  hit;
    r   = cur;
    hit = 1'b0;
    for (int k = 1; k <= SLOT_MAX; k++) begin
      if (k <= n && !hit) begin
        int idx;
        idx = (int'(cur) + k) % n;
        if (v[idx]) begin
          r   = sidx_t'(idx);
          hit = 1'b1;
        end
      end
    end
    return r;
  endfunction

  // setup steps: 6,7,2,3 ; poll steps: 0,1,2,3
  function automatic logic [2:0] step_offset(logic setup, logic [1:0] step);
    return (setup && !step[1]) ? {2'b11, step[0]} : {1'b0, step};
  endfunction

  function automatic logic offset_is_write(logic [2:0] off);
    return off[1];
  endfunction
endpackage

// File: rtl/hp_slot_qualify.sv
`timescale 1ns/1ps
module hp_slot_qualify #(
  parameter int NUM_SLOTS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] cap_i,
  input  logic [NUM_SLOTS-1:0] mem_i,
  input  logic [NUM_SLOTS-1:0] novpp_i,
  input  logic [NUM_SLOTS-1:0] done_i,
  output logic [NUM_SLOTS-1:0] valid_o,
  output logic [NUM_SLOTS-1:0] pend_o
);
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic qual_now;
    assign qual_now = cap_i[i] & (mem_i[i] | ~novpp_i[i]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_o[i] <= 1'b0;
        pend_o[i]  <= 1'b0;
      end else begin
        valid_o[i] <= qual_now;
        // set on rising qualification, kept until programmed, lost when disqualified
        pend_o[i]  <= qual_now & ((pend_o[i] & ~done_i[i]) | ~valid_o[i]);
      end
    end
  end
endmodule

// File: rtl/hp_input_bank.sv
`timescale 1ns/1ps
module hp_input_bank #(
  parameter int NUM_SLOTS = 6,
  parameter int PORT_W    = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  hp_seq_pkg::sidx_t               slot,
  input  logic                            hi,
  input  logic [PORT_W-1:0]               data,
  output logic [NUM_SLOTS*2*PORT_W-1:0]   bank,
  output logic [NUM_SLOTS-1:0]            upd
);
  localparam int PAIR_W = 2 * PORT_W;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_bank
    logic hit;
    assign hit = wr_en && (slot == hp_seq_pkg::sidx_t'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bank[i*PAIR_W +: PAIR_W] <= '0;
        upd[i]                   <= 1'b0;
      end else begin
        upd[i] <= hit;
        if (hit) begin
          if (hi) bank[i*PAIR_W + PORT_W +: PORT_W] <= data;
          else    bank[i*PAIR_W +: PORT_W]          <= data;
        end
      end
    end
  end
endmodule

// File: rtl/hp_expander_seq.sv
`timescale 1ns/1ps
module hp_expander_seq
  import hp_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 6,
  parameter int DEV_W     = 7,
  parameter int PORT_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_SLOTS-1:0]          slot_cap,
  input  logic [NUM_SLOTS-1:0]          slot_mem,
  input  logic [NUM_SLOTS-1:0]          slot_novpp,
  input  logic [NUM_SLOTS*DEV_W-1:0]    slot_dev,
  input  logic [NUM_SLOTS*2*PORT_W-1:0] slot_dir,
  input  logic [NUM_SLOTS*2*PORT_W-1:0] slot_drive,
  output logic [NUM_SLOTS*2*PORT_W-1:0] slot_in,
  output logic [NUM_SLOTS-1:0]          slot_in_upd,
  output logic                          cmd_req,
  output logic [DEV_W-1:0]              cmd_dev,
  output logic [2:0]                    cmd_off,
  output logic                          cmd_wr,
  output logic [PORT_W-1:0]             cmd_wdata,
  input  logic                          cmd_ack,
  input  logic [PORT_W-1:0]             cmd_rdata
);
  localparam int PAIR_W = 2 * PORT_W;

  // per-slot qualification and pending-programming flags
  logic [NUM_SLOTS-1:0] valid_q, pend_q, done_n;
  slot_vec_t            valid_v, pend_v;

  hp_slot_qualify #(.NUM_SLOTS(NUM_SLOTS)) u_qual (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_i   (slot_cap),
    .mem_i   (slot_mem),
    .novpp_i (slot_novpp),
    .done_i  (done_n),
    .valid_o (valid_q),
    .pend_o  (pend_q)
  );

  assign valid_v = slot_vec_t'(valid_q);
  assign pend_v  = slot_vec_t'(pend_q);

  // padded per-slot views, indexable by a slot index
  logic [DEV_W-1:0]  dev_a [SLOT_MAX];
  logic [PAIR_W-1:0] dir_a [SLOT_MAX];
  logic [PAIR_W-1:0] drv_a [SLOT_MAX];

  for (genvar i = 0; i < SLOT_MAX; i++) begin : g_view
    if (i < NUM_SLOTS) begin : g_real
      assign dev_a[i] = slot_dev[i*DEV_W +: DEV_W];
      assign dir_a[i] = slot_dir[i*PAIR_W +: PAIR_W];
      assign drv_a[i] = slot_drive[i*PAIR_W +: PAIR_W];
    end else begin : g_pad
      assign dev_a[i] = '0;
      assign dir_a[i] = '0;
      assign drv_a[i] = '0;
    end
  end

  // sequencing state
  logic        busy;
  logic        cur_setup;
  sidx_t       cur_slot;
  logic [1:0]  cur_step;
  sidx_t       poll_slot;
  logic [1:0]  poll_step;
  logic        setup_run;
  sidx_t       setup_slot;
  logic [1:0]  setup_step;

  // named events for the checker
  logic        issue;
  logic        xfer_done;
  logic        rd_done;
  logic        any_valid;
  logic        resume_setup;
  logic        fresh_setup;
  logic        last_step;

  logic        sel_setup;
  sidx_t       sel_slot;
  logic [1:0]  sel_step;
  logic [2:0]  sel_off;
  logic [PORT_W-1:0] sel_data;
  logic [PAIR_W-1:0] sel_pair;

  assign any_valid    = |valid_v;
  assign resume_setup = setup_run & valid_v[setup_slot];
  assign fresh_setup  = |pend_v;
  assign xfer_done    = busy & cmd_ack;
  assign rd_done      = xfer_done & ~cmd_wr;
  assign last_step    = (cur_step == 2'd3);

  always_comb begin
    issue     = 1'b0;
    sel_setup = 1'b0;
    sel_slot  = poll_slot;
    sel_step  = poll_step;
    if (!busy) begin
      if (resume_setup) begin
        issue     = 1'b1;
        sel_setup = 1'b1;
        sel_slot  = setup_slot;
        sel_step  = setup_step;
      end else if (fresh_setup) begin
        issue     = 1'b1;
        sel_setup = 1'b1;
        sel_slot  = lowest_set(pend_v);
        sel_step  = 2'd0;
      end else if (any_valid) begin
        issue = 1'b1;
        if (!valid_v[poll_slot]) begin
          sel_slot = next_set_after(valid_v, poll_slot, NUM_SLOTS);
          sel_step = 2'd0;
        end
      end
    end
  end

  assign sel_off  = step_offset(sel_setup, sel_step);
  assign sel_pair = sel_off[2] ? dir_a[sel_slot] : drv_a[sel_slot];
  assign sel_data = sel_off[0] ? sel_pair[PAIR_W-1:PORT_W] : sel_pair[PORT_W-1:0];

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_done
    assign done_n[i] = xfer_done & cur_setup & last_step & (cur_slot == sidx_t'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      cmd_req    <= 1'b0;
      cmd_dev    <= '0;
      cmd_off    <= '0;
      cmd_wr     <= 1'b0;
      cmd_wdata  <= '0;
      cur_setup  <= 1'b0;
      cur_slot   <= '0;
      cur_step   <= '0;
      poll_slot  <= '0;
      poll_step  <= '0;
      setup_run  <= 1'b0;
      setup_slot <= '0;
      setup_step <= '0;
    end else begin
      if (issue) begin
        busy      <= 1'b1;
        cmd_req   <= 1'b1;
        cmd_dev   <= dev_a[sel_slot];
        cmd_off   <= sel_off;
        cmd_wr    <= offset_is_write(sel_off);
        cmd_wdata <= sel_data;
        cur_setup <= sel_setup;
        cur_slot  <= sel_slot;
        cur_step  <= sel_step;
        setup_run <= sel_setup;
        if (sel_setup) begin
          setup_slot <= sel_slot;
          setup_step <= sel_step;
        end
      end else if (!busy) begin
        setup_run <= 1'b0;
      end

      if (xfer_done) begin
        busy    <= 1'b0;
        cmd_req <= 1'b0;
        if (cur_setup) begin
          if (last_step) setup_run  <= 1'b0;
          else           setup_step <= cur_step + 2'd1;
        end else if (last_step) begin
          poll_slot <= next_set_after(valid_v, cur_slot, NUM_SLOTS);
          poll_step <= 2'd0;
        end else begin
          poll_slot <= cur_slot;
          poll_step <= cur_step + 2'd1;
        end
      end
    end
  end

  hp_input_bank #(.NUM_SLOTS(NUM_SLOTS), .PORT_W(PORT_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (rd_done),
    .slot  (cur_slot),
    .hi    (cur_step[0]),
    .data  (cmd_rdata),
    .bank  (slot_in),
    .upd   (slot_in_upd)
  );
endmodule

// File: rtl/hp_expander_seq_chk.sv
`timescale 1ns/1ps
module hp_expander_seq_chk #(
  parameter int NUM_SLOTS = 6,
  parameter int DEV_W     = 7,
  parameter int PORT_W    = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cmd_req,
  input logic                     cmd_ack,
  input logic [DEV_W-1:0]         cmd_dev,
  input logic [2:0]               cmd_off,
  input logic                     cmd_wr,
  input logic [PORT_W-1:0]        cmd_wdata,
  input logic [NUM_SLOTS-1:0]     slot_in_upd,
  input hp_seq_pkg::slot_vec_t    valid_v,
  input hp_seq_pkg::sidx_t        cur_slot,
  input logic                     any_valid
);
  hp_seq_pkg::slot_vec_t valid_prev;
  always_ff @(posedge clk) begin
    if (!rst_n) valid_prev <= '0;
    else        valid_prev <= valid_v;
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req && !cmd_ack |=> cmd_req && $stable(cmd_dev) && $stable(cmd_off)
                            && $stable(cmd_wr) && $stable(cmd_wdata));

  assert_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req && cmd_ack |=> !cmd_req);

  assert_no_polarity_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |-> (cmd_off != 3'd4) && (cmd_off != 3'd5));

  assert_rw_by_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |-> cmd_wr == cmd_off[1]);

  assert_target_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_req) |-> valid_prev[cur_slot]);

  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|slot_in_upd) |=> !(|slot_in_upd));

  assert_strobe_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_in_upd));

  assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !any_valid && !cmd_req |=> !cmd_req);
endmodule

bind hp_expander_seq hp_expander_seq_chk #(
  .NUM_SLOTS(NUM_SLOTS), .DEV_W(DEV_W), .PORT_W(PORT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_req     (cmd_req),
  .cmd_ack     (cmd_ack),
  .cmd_dev     (cmd_dev),
  .cmd_off     (cmd_off),
  .cmd_wr      (cmd_wr),
  .cmd_wdata   (cmd_wdata),
  .slot_in_upd (slot_in_upd),
  .valid_v     (valid_v),
  .cur_slot    (cur_slot),
  .any_valid   (any_valid)
);

// File: tb/hp_expander_seq_test.sv
`timescale 1ns/1ps
module hp_expander_seq_test;
  localparam int NS   = 6;
  localparam int LOGN = 1024;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NS-1:0]   slot_cap = '0, slot_mem = '0, slot_novpp = '0;
  logic [NS*7-1:0] slot_dev = '0;
  logic [NS*16-1:0] slot_dir = '0, slot_drive = '0;
  logic [NS*16-1:0] slot_in;
  logic [NS-1:0]   slot_in_upd;
  logic            cmd_req, cmd_wr;
  logic [6:0]      cmd_dev;
  logic [2:0]      cmd_off;
  logic [7:0]      cmd_wdata;
  logic            cmd_ack = 1'b0;
  logic [7:0]      cmd_rdata = '0;

  always #4 clk = ~clk;

  hp_expander_seq uut (
    .clk(clk), .rst_n(rst_n), .slot_cap(slot_cap), .slot_mem(slot_mem),
    .slot_novpp(slot_novpp), .slot_dev(slot_dev), .slot_dir(slot_dir),
    .slot_drive(slot_drive), .slot_in(slot_in), .slot_in_upd(slot_in_upd),
    .cmd_req(cmd_req), .cmd_dev(cmd_dev), .cmd_off(cmd_off), .cmd_wr(cmd_wr),
    .cmd_wdata(cmd_wdata), .cmd_ack(cmd_ack), .cmd_rdata(cmd_rdata)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // command log filled by the responder
  logic [6:0] l_dev [LOGN];
  logic [2:0] l_off [LOGN];
  logic       l_wr  [LOGN];
  logic [7:0] l_dat [LOGN];
  int log_n = 0;

  logic [7:0] exp_in [NS][2];
  int rd_cnt [NS];
  int upd_cnt [NS];
  int hold_err = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(int slot, int off);
    case (off)
      6: return 8'h30 + 8'(slot);
      7: return 8'hC0 + 8'(slot);
      2: return 8'h50 + 8'(slot);
      default: return 8'hA0 + 8'(slot);
    endcase
  endfunction

  function automatic int slot_of(logic [6:0] d);
    return int'(d) - 32;
  endfunction

  // responder: acknowledges after a varying delay, records each command
  initial begin : responder
    int lat = 0;
    int wcnt = 0;
    bit have_prev = 0;
    logic [18:0] prev = '0;
    logic [7:0] seed = 8'h17;
    for (int i = 0; i < NS; i++) begin
      rd_cnt[i] = 0;
      exp_in[i][0] = '0;
      exp_in[i][1] = '0;
    end
    forever begin
      @(negedge clk);
      if (cmd_ack) begin
        cmd_ack = 1'b0;
      end else if (cmd_req) begin
        if (have_prev && prev != {cmd_dev, cmd_off, cmd_wr, cmd_wdata}) hold_err++;
        prev = {cmd_dev, cmd_off, cmd_wr, cmd_wdata};
        have_prev = 1;
        if (wcnt >= lat) begin
          if (log_n < LOGN) begin
            l_dev[log_n] = cmd_dev;
            l_off[log_n] = cmd_off;
            l_wr[log_n]  = cmd_wr;
            l_dat[log_n] = cmd_wdata;
            log_n++;
          end
          seed = seed * 8'd5 + 8'd3;
          cmd_rdata = seed;
          if (!cmd_wr && slot_of(cmd_dev) >= 0 && slot_of(cmd_dev) < NS && cmd_off < 3'd2) begin
            exp_in[slot_of(cmd_dev)][cmd_off[0]] = seed;
            rd_cnt[slot_of(cmd_dev)]++;
          end
          cmd_ack = 1'b1;
          have_prev = 0;
          wcnt = 0;
          lat = (lat + 1) % 4;
        end else begin
          wcnt++;
        end
      end
    end
  end

  initial begin : upd_mon
    for (int i = 0; i < NS; i++) upd_cnt[i] = 0;
    forever begin
      @(negedge clk);
      for (int i = 0; i < NS; i++) if (slot_in_upd[i]) upd_cnt[i]++;
    end
  end

  task automatic wait_entries(input int n);
    int g = 0;
    while (log_n < n && g < 5000) begin
      @(posedge clk);
      g++;
    end
  endtask

  task automatic check_cmd(input int k, input int slot, input int off, input string tag);
    logic exp_wr;
    bit ok;
    exp_wr = (off >= 2);
    ok = (l_dev[k] == 7'(32 + slot)) && (int'(l_off[k]) == off) && (l_wr[k] == exp_wr)
         && (!exp_wr || l_dat[k] == exp_byte(slot, off));
    check(ok, tag, {l_dev[k], l_off[k], l_wr[k], l_dat[k]},
          {7'(32 + slot), 3'(off), exp_wr, exp_wr ? exp_byte(slot, off) : l_dat[k]});
  endtask

  task automatic check_setup(input int k, input int slot);
    check_cmd(k,     slot, 6, "R3 setup cfg0");
    check_cmd(k + 1, slot, 7, "R3 setup cfg1");
    check_cmd(k + 2, slot, 2, "R3 setup out0");
    check_cmd(k + 3, slot, 3, "R3 setup out1");
  endtask

  function automatic int find_first(input int from, input int slot);
    for (int k = from; k < log_n; k++) if (slot_of(l_dev[k]) == slot) return k;
    return -1;
  endfunction

  // R1, R2: silence after reset and for a disabled card slot
  task automatic t_reset;
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(cmd_req == 1'b0, "R1 req after reset", cmd_req, 0);
    check(slot_in == '0 && slot_in_upd == '0, "R1 inputs clear", slot_in, 0);
    slot_cap[1] = 1'b1; slot_novpp[1] = 1'b1; slot_mem[1] = 1'b0;
    repeat (40) @(posedge clk);
    check(log_n == 0, "R2 card slot with expander disabled stays silent", log_n, 0);
  endtask

  // R3, R6: single memory slot programmed then polled
  task automatic t_single;
    slot_cap[1] = 1'b0;
    @(posedge clk);
    log_n = 0;
    slot_mem[2] = 1'b1; slot_novpp[2] = 1'b1; slot_cap[2] = 1'b1;
    wait_entries(12);
    check_setup(0, 2);
    for (int g = 0; g < 2; g++) begin
      check_cmd(4 + 4*g, 2, 0, "R6 poll rd0");
      check_cmd(5 + 4*g, 2, 1, "R6 poll rd1");
      check_cmd(6 + 4*g, 2, 2, "R6 poll wr2");
      check_cmd(7 + 4*g, 2, 3, "R6 poll wr3");
    end
  endtask

  // R4, R2, R7, R5: pre-emption, disable flag, ascending order
  task automatic t_multi;
    int j0, f, j1, g4, bad, bad5;
    int g = 0;
    while (!(log_n % 4 == 1 && cmd_req) && g < 2000) begin
      @(posedge clk);
      g++;
    end
    j0 = log_n;
    slot_mem[0] = 1'b0; slot_novpp[0] = 1'b0; slot_cap[0] = 1'b1;
    slot_mem[4] = 1'b0; slot_novpp[4] = 1'b1; slot_cap[4] = 1'b1;
    wait_entries(j0 + 24);
    f = find_first(0, 0);
    check(f == j0 || f == j0 + 1, "R4 setup right after command in flight", f, j0);
    if (f >= 0) check_setup(f, 0);
    check(find_first(0, 4) < 0, "R2 disabled card slot not addressed", find_first(0, 4), -1);
    j1 = log_n;
    slot_novpp[4] = 1'b0;
    wait_entries(j1 + 48);
    g4 = find_first(j1, 4);
    check(g4 >= j1 && g4 <= j1 + 2, "R2 slot qualifies when flag clears", g4, j1);
    if (g4 >= 0) check_setup(g4, 4);
    bad = 0;
    for (int k = g4 + 4; k < log_n - 1; k++) begin
      if (l_off[k] < 3'd3) begin
        if (l_dev[k+1] != l_dev[k] || l_off[k+1] != l_off[k] + 3'd1) bad++;
      end else begin
        int s, nx;
        s = slot_of(l_dev[k]);
        nx = (s == 0) ? 2 : (s == 2) ? 4 : 0;
        if (slot_of(l_dev[k+1]) != nx || l_off[k+1] != 3'd0) bad++;
      end
    end
    check(bad == 0 && g4 >= 0, "R7 ascending order with wrap and skips", bad, 0);
    bad5 = 0;
    for (int k = 0; k < log_n; k++) if (l_off[k] == 3'd4 || l_off[k] == 3'd5) bad5++;
    check(bad5 == 0, "R5 polarity untouched", bad5, 0);
  endtask

  // R9, R8, R10: shutdown, sampled bytes, strobes, handshake
  task automatic t_idle;
    int n;
    slot_cap = '0;
    repeat (20) @(posedge clk);
    n = log_n;
    repeat (60) @(posedge clk);
    @(negedge clk);
    check(log_n == n && cmd_req == 1'b0, "R9 idle after all slots off", log_n, n);
    for (int i = 0; i < NS; i++) begin
      check(slot_in[i*16 +: 16] == {exp_in[i][1], exp_in[i][0]}, "R8 sampled bytes",
            slot_in[i*16 +: 16], {exp_in[i][1], exp_in[i][0]});
      check(upd_cnt[i] == rd_cnt[i], "R8 one strobe per read", upd_cnt[i], rd_cnt[i]);
    end
    check(hold_err == 0, "R10 fields stable while waiting", hold_err, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    for (int i = 0; i < NS; i++) begin
      slot_dev[i*7 +: 7]     = 7'(32 + i);
      slot_dir[i*16 +: 16]   = {8'hC0 + 8'(i), 8'h30 + 8'(i)};
      slot_drive[i*16 +: 16] = {8'hA0 + 8'(i), 8'h50 + 8'(i)};
    end
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_multi();
    t_idle();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule